// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block is the software-visible face of a hardware random number generator. A simple 32-bit read/write bus reaches five word registers: control, status, data, noise-source control and health-test control. The control register enables generation, sets the entropy clock divider and the entropy-source settings, and carries a conditional-reset bit and a one-way configuration lock. The status register shows data ready, live seed and clock error states, and sticky copies of both errors.

The entropy source is modelled. A maximal-length 32-bit LFSR advances on each prescaled entropy tick, and a word is offered after a fixed number of ticks. Two inputs inject seed and clock errors. Configuration is only accepted in the write that raises the conditional-reset bit. The noise and health registers are only writable while that bit reads one. Software drops the bit, and hardware clears it after a fixed drain time; generation is paused until then. After a seed error, data reads return zero until a conditional reset completes.

Top module: `trng_csr`

## Requirements
- R1: After reset every register (control 0x00, status 0x04, data 0x08, noise 0x0C, health 0x10) reads zero.
- R2: Control bits 25:8 and bit 5 change only on a control write with bit 30 set. Writes to noise (0x0C) and health (0x10) land only while control bit 30 reads one. All other writes to them are ignored.
- R3: The noise register keeps only bits 17:0; bits 31:18 read zero.
- R4: Control bit 30 reads one after a write setting it. After a write clearing it, the bit stays one for CLR_DLY (8) cycles, then hardware clears it. No word is produced while it reads one.
- R5: Status bit 0 sets when a word is available. A data read (0x08) returns a nonzero word and clears bit 0. Consecutive words differ.
- R6: With enable (control bit 2) set, a word becomes available WORD_TICKS (4) entropy ticks after bit 0 clears. Ticks occur once every 2^D clocks, with D in control bits 19:16.
- R7: A seed error input sets status bit 2 (live) and bit 6 (sticky), clears bit 0 and stops word production.
- R8: A data read while status bit 2 is set returns zero.
- R9: Writing zero to status bit 5 or 6 clears that flag; writing one leaves it unchanged.
- R10: A sticky flag set in the same cycle as a software clear of it stays set.
- R11: Completion of a conditional reset clears status bit 2, and word production resumes.
- R12: With control bit 5 set, the clock error input drives status bit 1 live and sets sticky bit 5. With bit 5 clear, the input is ignored.
- R13: Once control bit 31 is written one, it and bits 25:8 and 5 stay frozen until rst_ni; bit 2 remains writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| seed_err_i | input | 1 | Injected seed (noise source) error |
| clk_err_i | input | 1 | Injected entropy clock error |

## Verification
Two things can land in the same cycle: the hardware setting a sticky error flag, and software writing zero to clear that flag. The bench raises the seed error input in the exact cycle a zero is written to the status register. A following status read must still show the sticky seed bit set. A second clear, with no error pending, must then take effect. The bench also measures the gap between a data read and the next data-ready at two divider settings, to tie the entropy rate to the divide field.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned NOISE_W = 18;
  localparam int unsigned DIV_W   = 4;

  localparam logic [2:0] IDX_CTRL  = 3'd0;
  localparam logic [2:0] IDX_STAT  = 3'd1;
  localparam logic [2:0] IDX_DATA  = 3'd2;
  localparam logic [2:0] IDX_NOISE = 3'd3;
  localparam logic [2:0] IDX_HLTH  = 3'd4;

  localparam int unsigned CB_EN     = 2;
  localparam int unsigned CB_CED    = 5;
  localparam int unsigned CB_CFG_LO = 8;
  localparam int unsigned CB_CFG_HI = 25;
  localparam int unsigned CB_DIV_LO = 16;
  localparam int unsigned CB_CND    = 30;
  localparam int unsigned CB_LOCK   = 31;
  localparam int unsigned CFG_W     = CB_CFG_HI - CB_CFG_LO + 1;

  localparam int unsigned SB_RDY      = 0;
  localparam int unsigned SB_CLK      = 1;
  localparam int unsigned SB_SEED     = 2;
  localparam int unsigned SB_CLK_STK  = 5;
  localparam int unsigned SB_SEED_STK = 6;

  typedef enum logic [1:0] {
    CND_IDLE  = 2'd0,
    CND_ARMED = 2'd1,
    CND_DRAIN = 2'd2
  } cnd_state_e;
endpackage

// File: rtl/trng_cond_seq.sv
module trng_cond_seq
  import trng_pkg::*;
#(
  parameter int unsigned CLR_DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic set_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (CLR_DLY > 1) ? $clog2(CLR_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLR_DLY - 1);

  cnd_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic arm;

  assign arm    = wr_i && set_i;
  assign busy_o = (state_q != CND_IDLE);
  assign done_o = (state_q == CND_DRAIN) && (cnt_q == LAST) && !arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CND_IDLE;
      cnt_q   <= '0;
    end else if (arm) begin
      state_q <= CND_ARMED;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CND_ARMED: if (wr_i) begin
          state_q <= CND_DRAIN;
          cnt_q   <= '0;
        end
        CND_DRAIN: begin
          if (cnt_q == LAST) state_q <= CND_IDLE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= CND_IDLE;
      endcase
    end
  end

  // R4
  cnd_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> busy_o);
  // R4
  cnd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/trng_prescaler.sv
module trng_prescaler #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = 2 ** DIV_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask   = (CNT_W'(1) << div_i) - CNT_W'(1);
  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  // R6
  tick_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i);
endmodule

// File: rtl/trng_word_src.sv
module trng_word_src #(
  parameter int unsigned      WORD_W     = 32,
  parameter int unsigned      WORD_TICKS = 4,
  parameter logic [WORD_W-1:0] POLY      = 32'h8020_0003,
  parameter logic [WORD_W-1:0] SEED      = 32'h6D2B_79F5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              hold_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned TCW = (WORD_TICKS > 1) ? $clog2(WORD_TICKS) : 1;
  localparam logic [TCW-1:0] TLAST = TCW'(WORD_TICKS - 1);

  logic [WORD_W-1:0] lfsr_q, lfsr_nxt;
  logic [TCW-1:0]    tcnt_q;
  logic              adv;

  assign lfsr_nxt = {1'b0, lfsr_q[WORD_W-1:1]} ^ (lfsr_q[0] ? POLY : '0);
  assign adv      = run_i && tick_i && !hold_i;
  assign load_o   = adv && (tcnt_q == TLAST);
  assign word_o   = lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= SEED;
    else if (tick_i)  lfsr_q <= lfsr_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tcnt_q <= '0;
    else if (!run_i)  tcnt_q <= '0;
    else if (adv)     tcnt_q <= load_o ? '0 : tcnt_q + 1'b1;
  end

  // R5
  no_b2b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  // R5
  word_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (word_o != '0));
endmodule

// File: rtl/trng_csr.sv
module trng_csr
  import trng_pkg::*;
#(
  parameter int unsigned CLR_DLY    = 8,
  parameter int unsigned WORD_TICKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              seed_err_i,
  input  logic              clk_err_i
);
  localparam int unsigned DIV_OFS = CB_DIV_LO - CB_CFG_LO;

  logic              hit;
  logic [2:0]        sel;
  logic              wr, rd;
  logic              wr_ctrl, wr_stat, wr_noise, wr_hlth, dr_rd;
  logic              cnd_set, cnd_busy, cnd_done;
  logic              run, tick, load;
  logic [REG_DW-1:0] word;

  logic [CFG_W-1:0]   cfg_q;
  logic               ced_q, en_q, lock_q;
  logic [NOISE_W-1:0] noise_q;
  logic [REG_DW-1:0]  hlth_q, data_q;
  logic               drdy_q, secs_q, seis_q, cecs_q, ceis_q;
  logic               clk_evt;

  assign sel      = addr_i[4:2];
  assign hit      = req_i && (addr_i[1:0] == 2'b00);
  assign wr       = hit && we_i;
  assign rd       = hit && !we_i;
  assign wr_ctrl  = wr && (sel == IDX_CTRL);
  assign wr_stat  = wr && (sel == IDX_STAT);
  assign wr_noise = wr && (sel == IDX_NOISE);
  assign wr_hlth  = wr && (sel == IDX_HLTH);
  assign dr_rd    = rd && (sel == IDX_DATA);
  assign cnd_set  = wr_ctrl && wdata_i[CB_CND];
  assign run      = en_q && !cnd_busy && !secs_q;
  assign clk_evt  = ced_q && clk_err_i;

  trng_cond_seq #(.CLR_DLY(CLR_DLY)) u_cnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_ctrl),
    .set_i  (wdata_i[CB_CND]),
    .busy_o (cnd_busy),
    .done_o (cnd_done)
  );

  trng_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (cfg_q[DIV_OFS +: DIV_W]),
    .tick_o (tick)
  );

  trng_word_src #(.WORD_W(REG_DW), .WORD_TICKS(WORD_TICKS)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick),
    .hold_i (drdy_q),
    .load_o (load),
    .word_o (word)
  );

  // control register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      ced_q  <= 1'b0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= wdata_i[CB_EN];
      if (!lock_q) begin
        lock_q <= wdata_i[CB_LOCK];
        if (wdata_i[CB_CND]) begin
          cfg_q <= wdata_i[CB_CFG_HI:CB_CFG_LO];
          ced_q <= wdata_i[CB_CED];
        end
      end
    end
  end

  // noise / health, accepted only inside a conditional reset window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      noise_q <= '0;
      hlth_q  <= '0;
    end else begin
      if (wr_noise && cnd_busy) noise_q <= wdata_i[NOISE_W-1:0];
      if (wr_hlth && cnd_busy)  hlth_q  <= wdata_i;
    end
  end

  // data path and ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      drdy_q <= 1'b0;
    end else begin
      if (load) data_q <= word;
      if (seed_err_i || cnd_done) drdy_q <= 1'b0;
      else if (load)              drdy_q <= 1'b1;
      else if (dr_rd)             drdy_q <= 1'b0;
    end
  end

  // error state: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q <= 1'b0;
      seis_q <= 1'b0;
      cecs_q <= 1'b0;
      ceis_q <= 1'b0;
    end else begin
      if (seed_err_i)    secs_q <= 1'b1;
      else if (cnd_done) secs_q <= 1'b0;

      if (seed_err_i)                            seis_q <= 1'b1;
      else if (wr_stat && !wdata_i[SB_SEED_STK]) seis_q <= 1'b0;

      cecs_q <= clk_evt;
      if (clk_evt)                              ceis_q <= 1'b1;
      else if (wr_stat && !wdata_i[SB_CLK_STK]) ceis_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        IDX_CTRL: begin
          rdata_o[CB_CFG_HI:CB_CFG_LO] = cfg_q;
          rdata_o[CB_EN]   = en_q;
          rdata_o[CB_CED]  = ced_q;
          rdata_o[CB_CND]  = cnd_busy;
          rdata_o[CB_LOCK] = lock_q;
        end
        IDX_STAT: begin
          rdata_o[SB_RDY]      = drdy_q;
          rdata_o[SB_CLK]      = cecs_q;
          rdata_o[SB_SEED]     = secs_q;
          rdata_o[SB_CLK_STK]  = ceis_q;
          rdata_o[SB_SEED_STK] = seis_q;
        end
        IDX_DATA:  rdata_o = secs_q ? '0 : data_q;
        IDX_NOISE: rdata_o[NOISE_W-1:0] = noise_q;
        IDX_HLTH:  rdata_o = hlth_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  // R7
  seed_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_err_i |=> (secs_q && seis_q && !drdy_q));
  // R5
  rdy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_rd && drdy_q) |=> !drdy_q);
  // R8
  zero_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_rd && secs_q) |-> (rdata_o == '0));
  // R13
  lock_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> (lock_q && $stable(cfg_q) && $stable(ced_q)));
  // R9
  stk_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seis_q && !(wr_stat && !wdata_i[SB_SEED_STK])) |=> seis_q);
  // R12
  ced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ced_q |=> !cecs_q);
endmodule

// File: tb/trng_csr_tb_top.sv
`timescale 1ns/1ps
module trng_csr_tb_top;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                         A_NOISE = 5'h0C, A_HLTH = 5'h10;
  localparam logic [31:0] EN = 32'h4, CED = 32'h20, COND = 32'h4000_0000,
                          LOCK = 32'h8000_0000;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] CTL_M = 32'h83FF_FF24;
  localparam int CLR_DLY = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, seed_err_i = 0, clk_err_i = 0;
  logic [4:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  logic [31:0] act_q[$], exp_q[$], msk_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  trng_csr dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .seed_err_i(seed_err_i), .clk_err_i(clk_err_i)
  );

  function automatic logic [31:0] mk_cfg(input int d);
    return (32'hA << 8) | (32'h1 << 12) | (32'h5 << 13) | (32'(d) << 16) | (32'h2B << 20);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd_val(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    #1 v = rdata_o;
    @(posedge clk); #1;
    req_i = 0;
  endtask

  // driver side of the scoreboard: expected item in, actual item in
  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input logic [31:0] m,
                        input string tag);
    logic [31:0] v;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(tag);
    rd_val(a, v);
    act_q.push_back(v);
  endtask

  task automatic poll(input logic [4:0] a, input int b, input logic val, input int lim,
                      output int n);
    n = 0;
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    #1;
    while (rdata_o[b] !== val && n < lim) begin
      @(negedge clk); #1; n++;
    end
    @(posedge clk); #1;
    req_i = 0;
  endtask

  task automatic recfg(input logic [31:0] cfg, input logic [31:0] enb, input string tag);
    int n;
    wr(A_CTRL, COND | cfg | enb);
    wr(A_CTRL, enb);
    poll(A_CTRL, 30, 1'b0, 40, n);
    chk(n < 40, tag, 32'(n), 32'(CLR_DLY));
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor side of the scoreboard
  initial begin
    logic [31:0] a, e, m;
    string t;
    forever begin
      wait (act_q.size() != 0);
      a = act_q.pop_front(); e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
      chk((a & m) === (e & m), t, a & m, e & m);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    logic [31:0] w1, w2, v;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    rd_chk(A_CTRL, 0, ALL, "R1 ctrl reset");
    rd_chk(A_STAT, 0, ALL, "R1 status reset");
    rd_chk(A_DATA, 0, ALL, "R1 data reset");
    rd_chk(A_NOISE, 0, ALL, "R1 noise reset");
    rd_chk(A_HLTH, 0, ALL, "R1 health reset");

    wr(A_NOISE, ALL);
    rd_chk(A_NOISE, 0, ALL, "R2 noise write outside window");
    wr(A_CTRL, mk_cfg(0) | CED);
    rd_chk(A_CTRL, 0, ALL, "R2 cfg write without bit30");

    wr(A_CTRL, COND | mk_cfg(0) | CED);
    rd_chk(A_CTRL, COND | mk_cfg(0) | CED, ALL, "R2 cfg latched with bit30");
    wr(A_NOISE, ALL);
    rd_chk(A_NOISE, 32'h0003_FFFF, ALL, "R3 noise width");
    wr(A_HLTH, 32'hA5A5_0F0F);
    rd_chk(A_HLTH, 32'hA5A5_0F0F, ALL, "R2 health in window");

    wr(A_CTRL, EN);
    rd_chk(A_CTRL, COND | mk_cfg(0) | CED | EN, ALL, "R4 bit30 held, R2 cfg kept");
    poll(A_CTRL, 30, 1'b0, 40, n);
    chk(n >= CLR_DLY - 3 && n <= CLR_DLY + 2, "R4 hw clear delay", 32'(n), 32'(CLR_DLY));
    rd_chk(A_STAT, 0, 32'h1, "R4 no word during reset");
    rd_chk(A_CTRL, mk_cfg(0) | CED | EN, ALL, "R4 ctrl after clear");

    poll(A_STAT, 0, 1'b1, 60, n);
    chk(n < 60, "R5 first ready", 32'(n), 32'h1);
    rd_val(A_DATA, w1);
    chk(w1 != 0, "R5 word nonzero", w1, 32'h1);
    rd_chk(A_STAT, 0, 32'h1, "R5 ready cleared by read");
    poll(A_STAT, 0, 1'b1, 60, n);
    chk(n >= 3 && n <= 8, "R6 gap div0", 32'(n), 32'h4);
    rd_val(A_DATA, w2);
    chk(w2 != 0 && w2 != w1, "R5 words differ", w2, w1);

    recfg(mk_cfg(3) | CED, EN, "R4 reconfig div3");
    poll(A_STAT, 0, 1'b1, 100, n);
    rd_val(A_DATA, v);
    poll(A_STAT, 0, 1'b1, 100, n);
    chk(n >= 24 && n <= 40, "R6 gap div3", 32'(n), 32'd32);

    @(negedge clk) seed_err_i = 1;
    @(posedge clk); #1 seed_err_i = 0;
    rd_chk(A_STAT, 32'h44, ALL, "R7 seed flags set, ready cleared");
    rd_chk(A_DATA, 0, ALL, "R8 data zero after seed error");
    repeat (60) @(posedge clk);
    rd_chk(A_STAT, 0, 32'h1, "R7 generation stopped");

    wr(A_STAT, ALL);
    rd_chk(A_STAT, 32'h44, ALL, "R9 write one no effect");
    wr(A_STAT, 0);
    rd_chk(A_STAT, 32'h04, ALL, "R9 write zero clears sticky");

    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = A_STAT; wdata_i = 0; seed_err_i = 1;
    @(posedge clk); #1;
    req_i = 0; we_i = 0; seed_err_i = 0;
    rd_chk(A_STAT, 32'h44, ALL, "R10 set wins over clear");
    wr(A_STAT, 0);
    rd_chk(A_STAT, 32'h04, ALL, "R10 later clear takes");

    recfg(mk_cfg(0) | CED, EN, "R11 reset completes");
    rd_chk(A_STAT, 0, 32'h4, "R11 live seed cleared");
    poll(A_STAT, 0, 1'b1, 60, n);
    chk(n < 60, "R11 ready returns", 32'(n), 32'h4);
    rd_val(A_DATA, v);
    chk(v != 0, "R11 data resumes", v, 32'h1);

    @(negedge clk) clk_err_i = 1;
    repeat (2) @(posedge clk);
    rd_chk(A_STAT, 32'h22, 32'h22, "R12 clock error live and sticky");
    @(negedge clk) clk_err_i = 0;
    repeat (2) @(posedge clk);
    rd_chk(A_STAT, 32'h20, 32'h22, "R12 live drops, sticky holds");
    wr(A_STAT, 0);
    rd_chk(A_STAT, 0, 32'h60, "R9 clock sticky cleared");
    recfg(mk_cfg(0), EN, "R12 detect off");
    @(negedge clk) clk_err_i = 1;
    repeat (3) @(posedge clk);
    rd_chk(A_STAT, 0, 32'h22, "R12 ignored when detect off");
    @(negedge clk) clk_err_i = 0;

    wr(A_CTRL, EN | LOCK);
    rd_chk(A_CTRL, LOCK | mk_cfg(0) | EN, CTL_M, "R13 lock set");
    wr(A_CTRL, COND | mk_cfg(3) | CED | EN);
    rd_chk(A_CTRL, LOCK | mk_cfg(0) | EN, CTL_M, "R13 cfg frozen");
    wr(A_CTRL, 0);
    rd_chk(A_CTRL, LOCK | mk_cfg(0), CTL_M, "R13 lock sticky, enable writable");

    wait (act_q.size() == 0);
    #1;
    finish_up();
  end
endmodule